// File: doc/BRIEF.md
# Clocked Serial Shift Interface

This block moves one byte at a time over a three-wire synchronous link: a data output, a data input and a shared clock pin. The host, a small controller with a nibble-wide bus, programs a 4-bit mode register. It loads the byte as two 4-bit digits, pulses a start strobe and waits for the done pulse. It then reads the received byte back through the same two digit addresses. One right-shifting register serves both directions. Each falling edge of the transmit clock puts the next outgoing bit on the data output, starting with the least significant bit. Each rising edge shifts the sampled input bit in at the most significant end.

The transmit clock can come from a free-running internal prescaler, at one of six fixed ratios or at the fastest rate the system clock allows. In those cases the clock pin is driven. In the external setting the clock pin is an input: it passes through a two-flop synchroniser, and its edges are detected in the system clock domain. The top bit of the mode register decides whether the shared pin carries the serial clock or an ordinary port bit. When it is clear, the port's own data and enable pass straight through and no transfer can start.

The shift engine is a four-state machine. ST_IDLE goes to ST_ARM on an accepted start. ST_ARM goes to ST_LOW on a falling-edge event, where the clock drops and the data output updates. ST_LOW returns to ST_ARM on a rising-edge event, where the clock rises and a bit is shifted in, unless this was the eighth bit. In that case it goes to ST_FINISH instead. ST_FINISH returns to ST_IDLE unconditionally after one cycle.

Top module: `ser_xfer_unit`

## Requirements
- R1: After reset the mode register is 0, busy and done are low, both data digits read 0, and the shared pin follows the port inputs pio_out and pio_oe.
- R2: Mode bit 3 selects the pin function. With 0, pin_o equals pio_out and pin_oe equals pio_oe. With 1, pin_o carries the serial clock, and pin_oe is 1 for clock codes 0 to 6 and 0 for code 7.
- R3: Mode bits 2..0 hold the clock code. Codes 0, 1, 2, 3, 4 and 5 give transmit-clock half-periods of 2048, 512, 128, 32, 8 and 2 system-clock cycles (full periods 4096, 1024, 256, 64, 16 and 4).
- R4: Code 6 gives the fastest internally generated clock, with a half-period of one system-clock cycle. Code 7 takes the transmit clock from pin_i.
- R5: A mode write (mode_wr high in cycle N, value on bus_wdata) takes effect in cycle N+2. A start strobe in cycle N or N+1 is ignored, and a start in cycle N+2 is accepted.
- R6: The data register is read and written as two digits: address 6 holds bits 3..0 and address 7 holds bits 7..4. Reads of any other address return 0.
- R7: On each falling edge of the transmit clock, so takes the next transmit bit, bit 0 first.
- R8: si is sampled on each rising edge and shifted in at bit 7. After a transfer, bit k of the register holds the bit sampled at rising edge k+1.
- R9: A transfer is exactly 8 transmit-clock periods. Busy goes high in the cycle after an accepted start and falls after the eighth rising edge. Done is then high for exactly one cycle.
- R10: A data-digit read or write while busy raises acc_err in the same cycle, and such a write leaves the register unchanged.
- R11: With code 7, pin_i passes through a two-flop synchroniser, and its detected falling and rising edges drive the same shift behaviour as in R7 and R8.
- R12: With mode bit 3 at 0, the start strobe is ignored.
- R13: In the internal clock codes the serial clock idles high before and after every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Digit address for data accesses |
| bus_wdata | input | 4 | Write data for digits and mode register |
| bus_wr | input | 1 | Data-digit write strobe |
| bus_rd | input | 1 | Data-digit read strobe |
| mode_wr | input | 1 | Mode register write strobe |
| bus_rdata | output | 4 | Read data of the addressed digit |
| xfer_start | input | 1 | Start strobe for one 8-bit transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_err | output | 1 | Data access attempted while busy |
| si | input | 1 | Serial data input |
| so | output | 1 | Serial data output |
| pin_i | input | 1 | Shared pin input (external clock) |
| pin_o | output | 1 | Shared pin output value |
| pin_oe | output | 1 | Shared pin output enable |
| pio_out | input | 1 | Port data for the shared pin |
| pio_oe | input | 1 | Port output enable for the shared pin |

## Verification
The assertions take for granted that an external clock on pin_i has high and low phases of several system clocks, so that the synchroniser sees every level. They also assume that the host never changes the mode while a transfer runs. The stimulus keeps both phases of the external clock at six cycles. It writes the mode only while busy is low and then waits two cycles before starting, except in the directed cases that probe the settling window. The random bytes, clock codes and the bit position of the mid-transfer access are drawn from a seeded generator, and the expected values come from bench functions.

// File: rtl/ser_pkg.sv
package ser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_LOW,
        ST_FINISH
    } xfer_state_t;

    localparam logic [2:0] CODE_SYS = 3'd6;
    localparam logic [2:0] CODE_EXT = 3'd7;
endpackage

// File: rtl/ser_mode_reg.sv
module ser_mode_reg #(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output logic              settling
);
    logic [MODE_W-1:0] pend_q;
    logic              pend_v;

    // two-step path: capture, then apply one cycle later
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
            mode_q <= '0;
        end else begin
            pend_v <= mode_wr;
            if (mode_wr) pend_q <= wdata;
            if (pend_v)  mode_q <= pend_q;
        end
    end

    assign settling = mode_wr | pend_v;

    // R5: the mode only moves two cycles after a write strobe
    a_r5_mode_lag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(mode_wr, 2));
endmodule

// File: rtl/ser_clk_sel.sv
module ser_clk_sel
    import ser_pkg::*;
#(
    parameter int PRE_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic       pin_i,
    output logic       adv_fall,
    output logic       adv_rise,
    output logic       ext_mode
);
    logic [PRE_W-1:0]  presc_q;
    logic [PRE_W-1:0]  mask;
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              tick;
    logic              ext_rise;
    logic              ext_fall;
    int                sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_q + 1'b1;
    end

    // half-period of 2^sh cycles: tick when the low sh bits are all ones
    always_comb begin
        if (code == CODE_SYS) sh = 0;
        else                  sh = (PRE_W - 1) - 2 * int'(code);
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < sh);
        tick = &(presc_q | ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_N-2:0], pin_i};
            prev_q <= sync_q[SYNC_N-1];
        end
    end

    assign ext_rise = sync_q[SYNC_N-1] & ~prev_q;
    assign ext_fall = ~sync_q[SYNC_N-1] & prev_q;
    assign ext_mode = (code == CODE_EXT);
    assign adv_fall = ext_mode ? ext_fall : tick;
    assign adv_rise = ext_mode ? ext_rise : tick;

    // R11: a synchronised edge follows a matching level on the previous stage
    a_r11_rise_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |-> $past(sync_q[SYNC_N-2]));
endmodule

// File: rtl/ser_shift_fsm.sv
module ser_shift_fsm
    import ser_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DIG_W   = 4,
    parameter int ADDR_W  = 4,
    parameter int ADDR_LO = 6,
    parameter int ADDR_HI = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              adv_fall,
    input  logic              adv_rise,
    input  logic              si,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DIG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DIG_W-1:0]  bus_rdata,
    output logic              so,
    output logic              sck_q,
    output logic              busy,
    output logic              done,
    output logic              acc_err
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    xfer_state_t       state_q, state_d;
    logic [DATA_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              so_q;
    logic              hit_lo, hit_hi;

    assign hit_lo = (bus_addr == ADDR_W'(ADDR_LO));
    assign hit_hi = (bus_addr == ADDR_W'(ADDR_HI));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_ARM;
            ST_ARM:    if (adv_fall) state_d = ST_LOW;
            ST_LOW:    if (adv_rise) state_d = (cnt_q == LAST_BIT) ? ST_FINISH : ST_ARM;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        bus_rdata = '0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARM:    busy = 1'b1;
            ST_LOW:    busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
        if (hit_lo) bus_rdata = sr_q[DIG_W-1:0];
        if (hit_hi) bus_rdata = sr_q[DATA_W-1:DIG_W];
        acc_err = busy & (bus_wr | bus_rd) & (hit_lo | hit_hi);
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
            so_q  <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (bus_wr && hit_lo) sr_q[DIG_W-1:0]      <= bus_wdata;
                    if (bus_wr && hit_hi) sr_q[DATA_W-1:DIG_W] <= bus_wdata;
                end
                ST_ARM: if (adv_fall) begin
                    sck_q <= 1'b0;
                    so_q  <= sr_q[0];
                end
                ST_LOW: if (adv_rise) begin
                    sck_q <= 1'b1;
                    sr_q  <= {si, sr_q[DATA_W-1:1]};
                    cnt_q <= (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign so = so_q;

    // R9: done is a single-cycle pulse that directly follows busy
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);
    // R9: the bit counter is back at zero whenever the engine is idle
    a_r9_count_home: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));
    // R13: the serial clock is high outside a transfer
    a_r13_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_q);
    // R7: so only moves on a falling-edge step
    a_r7_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_q) |-> $past(state_q == ST_ARM) && !sck_q);
endmodule

// File: rtl/ser_xfer_unit.sv
module ser_xfer_unit
    import ser_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DIG_W   = 4,
    parameter int ADDR_W  = 4,
    parameter int PRE_W   = 12,
    parameter int SYNC_N  = 2,
    parameter int ADDR_LO = 6,
    parameter int ADDR_HI = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DIG_W-1:0]  bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              mode_wr,
    output logic [DIG_W-1:0]  bus_rdata,
    input  logic              xfer_start,
    output logic              busy,
    output logic              done,
    output logic              acc_err,
    input  logic              si,
    output logic              so,
    input  logic              pin_i,
    output logic              pin_o,
    output logic              pin_oe,
    input  logic              pio_out,
    input  logic              pio_oe
);
    logic [DIG_W-1:0] mode_q;
    logic             settling;
    logic             adv_fall, adv_rise, ext_mode;
    logic             sck_q;
    logic             sck_fn;
    logic             start_ok;

    ser_mode_reg #(.MODE_W(DIG_W)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_wr  (mode_wr),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .settling (settling)
    );

    ser_clk_sel #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .code     (mode_q[2:0]),
        .pin_i    (pin_i),
        .adv_fall (adv_fall),
        .adv_rise (adv_rise),
        .ext_mode (ext_mode)
    );

    assign sck_fn   = mode_q[3];
    assign start_ok = xfer_start & sck_fn & ~settling;

    ser_shift_fsm #(
        .DATA_W (DATA_W), .DIG_W (DIG_W), .ADDR_W (ADDR_W),
        .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ok  (start_ok),
        .adv_fall  (adv_fall),
        .adv_rise  (adv_rise),
        .si        (si),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .so        (so),
        .sck_q     (sck_q),
        .busy      (busy),
        .done      (done),
        .acc_err   (acc_err)
    );

    // shared pin function mux
    assign pin_o  = sck_fn ? sck_q     : pio_out;
    assign pin_oe = sck_fn ? ~ext_mode : pio_oe;

    // R5: an accepted start never sits inside the mode settling window
    a_r5_start_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(mode_wr, 1) && !$past(mode_wr, 2));
    // R12: transfers only begin with the clock pin function selected
    a_r12_port_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mode_q[3]));
endmodule

// File: tb/tb_ser_xfer_unit.sv
module tb_ser_xfer_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, mode_wr = 1'b0;
    logic [3:0] bus_rdata;
    logic       xfer_start = 1'b0;
    logic       busy, done, acc_err;
    logic       si = 1'b0;
    logic       so;
    logic       pin_i = 1'b1;
    logic       pin_o, pin_oe;
    logic       pio_out = 1'b0, pio_oe = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ser_xfer_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .mode_wr(mode_wr), .bus_rdata(bus_rdata),
        .xfer_start(xfer_start), .busy(busy), .done(done), .acc_err(acc_err),
        .si(si), .so(so), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
        .pio_out(pio_out), .pio_oe(pio_oe)
    );

    function automatic int half_of(input int code);
        return (code == 6) ? 1 : (1 << (11 - 2 * code));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mwrite(input logic [3:0] v);
        mode_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic dwrite(input logic [3:0] a, input logic [3:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic dread(input logic [3:0] a, output logic [3:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_byte(output logic [7:0] b);
        logic [3:0] lo, hi;
        dread(4'd6, lo);
        dread(4'd7, hi);
        b = {hi, lo};
    endtask

    task automatic load_and_start(input logic [7:0] tx, input logic s0);
        dwrite(4'd6, tx[3:0]);
        dwrite(4'd7, tx[7:4]);
        si = s0;
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        chk(busy == 1'b1, "R9 busy after start", busy, 1);
    endtask

    // internal-clock transfer with a bench serial partner
    task automatic xfer_int(input int code, input logic [7:0] tx, input logic [7:0] pb,
                            input int poke_at);
        int falls = 0, rises = 0, cnt = 0, halfbad = 0, lastbad = 0, lim = 0;
        logic prev;
        logic [7:0] got = '0, rx;
        bit poked = 1'b0, seen_done = 1'b0;
        mwrite({1'b1, 3'(code)});
        cyc(2);
        chk(pin_oe == 1'b1, "R2 pin driven in internal code", pin_oe, 1);
        chk(pin_o == 1'b1, "R13 clock idles high before transfer", pin_o, 1);
        load_and_start(tx, pb[0]);
        prev = pin_o;
        while (!seen_done && lim < 40000) begin
            @(negedge clk);
            bus_wr = 1'b0;
            lim++;
            cnt++;
            if (prev && !pin_o) begin falls++; cnt = 0; end
            if (!prev && pin_o) begin
                if (cnt != half_of(code)) begin halfbad++; lastbad = cnt; end
                if (rises < 8) got[rises] = so;
                rises++;
                if (rises < 8) si = pb[rises];
            end
            prev = pin_o;
            if (done) begin
                seen_done = 1'b1;
                chk(busy == 1'b0, "R9 busy low at done", busy, 0);
            end else if (rises == poke_at && !poked) begin
                poked = 1'b1;
                bus_addr = 4'd6; bus_wdata = ~pb[3:0]; bus_wr = 1'b1;
                #1 chk(acc_err == 1'b1, "R10 write while busy flagged", acc_err, 1);
            end
        end
        bus_wr = 1'b0;
        chk(seen_done, "R9 done pulse seen", seen_done, 1);
        chk(falls == 8 && rises == 8, "R9 eight clock periods", falls * 16 + rises, 8 * 16 + 8);
        chk(halfbad == 0, (code == 6) ? "R4 fastest half-period" : "R3 half-period of code",
            lastbad, half_of(code));
        chk(got == tx, "R7 SO bits LSB first", got, tx);
        cyc(1);
        chk(done == 1'b0, "R9 done lasts one cycle", done, 0);
        chk(pin_o == 1'b1, "R13 clock idles high after transfer", pin_o, 1);
        read_byte(rx);
        chk(rx == pb, (poke_at < 8) ? "R10 busy write ignored, R8 rx" : "R8 received byte",
            rx, pb);
    endtask

    // external-clock transfer, six cycles per phase
    task automatic xfer_ext(input logic [7:0] tx, input logic [7:0] pb);
        logic [7:0] got = '0, rx;
        bit seen_done = 1'b0;
        mwrite(4'hF);
        cyc(2);
        chk(pin_oe == 1'b0, "R2 pin released for external clock", pin_oe, 0);
        load_and_start(tx, pb[0]);
        for (int b = 0; b < 8; b++) begin
            pin_i = 1'b0; si = pb[b];
            cyc(6);
            got[b] = so;
            pin_i = 1'b1;
            for (int w = 0; w < 6; w++) begin
                @(negedge clk);
                if (done) seen_done = 1'b1;
            end
        end
        chk(seen_done, "R11 external transfer completes", seen_done, 1);
        chk(got == tx, "R11 SO bits on external clock", got, tx);
        read_byte(rx);
        chk(rx == pb, "R11 received byte on external clock", rx, pb);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] v;
        logic [7:0] b, rx;
        int unsigned seed;
        seed = $urandom(32'd1234);
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        pio_out = 1'b1; pio_oe = 1'b1; #1;
        chk(busy == 0 && done == 0, "R1 idle after reset", {busy, done}, 0);
        chk(pin_o == 1 && pin_oe == 1, "R1 pin follows port after reset", {pin_o, pin_oe}, 3);
        read_byte(rx);
        chk(rx == 8'h00, "R1 data register clear", rx, 0);

        // R6 digit access, random bytes
        for (int i = 0; i < 4; i++) begin
            b = 8'($urandom);
            dwrite(4'd6, b[3:0]);
            dwrite(4'd7, b[7:4]);
            dread(4'd6, v);
            chk(v == b[3:0], "R6 low digit", v, b[3:0]);
            dread(4'd7, v);
            chk(v == b[7:4], "R6 high digit", v, b[7:4]);
        end
        dread(4'd5, v);
        chk(v == 4'h0, "R6 other address reads zero", v, 0);

        // R2/R12 port function: passthrough and no start
        mwrite(4'h6);
        cyc(2);
        pio_out = 1'b0; pio_oe = 1'b1; #1;
        chk(pin_o == 0 && pin_oe == 1, "R2 port passthrough", {pin_o, pin_oe}, 1);
        xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
        cyc(2);
        chk(busy == 1'b0, "R12 start ignored in port mode", busy, 0);

        // R5 settling window
        mode_wr = 1'b1; bus_wdata = 4'hD; xfer_start = 1'b1;
        cyc(1);
        mode_wr = 1'b0; xfer_start = 1'b0;
        chk(busy == 1'b0, "R5 start in write cycle ignored", busy, 0);
        xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
        chk(busy == 1'b0, "R5 start one cycle after write ignored", busy, 0);
        mwrite(4'hD);
        xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
        chk(busy == 1'b0, "R5 start after second write ignored", busy, 0);
        xfer_start = 1'b1; cyc(1); xfer_start = 1'b0;
        chk(busy == 1'b1, "R5 start two cycles after write accepted", busy, 1);
        for (int w = 0; w < 200 && !done; w++) cyc(1);
        cyc(2);

        // directed corner transfers
        xfer_int(6, 8'h01, 8'h80, 9);
        xfer_int(5, 8'hFF, 8'h00, 3);
        xfer_int(0, 8'h5A, 8'hC3, 9);

        // random transfers
        for (int i = 0; i < 6; i++) begin
            xfer_int(3 + int'($urandom % 4), 8'($urandom), 8'($urandom),
                     int'($urandom % 10));
        end

        xfer_ext(8'hA6, 8'h39);
        xfer_ext(8'($urandom), 8'h81);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule